// File: doc/BRIEF.md
# Repeated String Copy Sequencer

This block runs a block copy between two memory regions, one element at a time, as a prefix-repeated string move does. A single start pulse gives it a source offset, a destination offset, a repeat count, a direction bit, a byte/word size select and two segment bases. For each element it makes one read and then one write. Each access carries a 20-bit physical address, built from a segment base and a 16-bit index.

The read side is a request held until a valid strobe comes back. The write side is a request held until a ready strobe comes back. The two index registers and the count register change only after an element's write has been accepted. They stay visible on the ports after the loop ends, so the pointer values the copy reached can be read. The block raises a one-cycle done pulse when the count runs out. A zero count gives a done pulse with no memory traffic.

Top module: `strmove_seq`

## Requirements
- R1: During and after reset, while no start has been seen, busy, done, rd_req and wr_req are 0, and src_idx, dst_idx and count read 0.
- R2: A start seen while idle loads both offsets, the count, the segments, the direction and the size select. If the loaded count is zero, no read or write request is made and done is 1 in the cycle right after the start edge.
- R3: The read address is (src_seg × 16 + src_idx) mod 2^20. The write address is (dst_seg × 16 + dst_idx) mod 2^20.
- R4: For each element, rd_req stays high with a steady address until a cycle with rd_valid high. In the next cycle wr_req rises and stays high until a cycle with wr_ready high. rd_req and wr_req are never high together.
- R5: wr_data is the rd_data captured in the read handshake cycle. In word mode (word_mode=1) all 16 bits are carried. In byte mode bits 15:8 are 0. wr_word reports the size select that was loaded.
- R6: On each write handshake, both indices move by the step (1 in byte mode, 2 in word mode): up when dir=0, down when dir=1, wrapping modulo 65536. count drops by one at the same handshake and changes at no other time except a load.
- R7: busy is high from the cycle after the start edge until the final write handshake. done is high for exactly one cycle after that handshake, and busy is low in that cycle.
- R8: Once idle, src_idx, dst_idx and count hold their final values until the next accepted start.
- R9: A start pulse during a transfer, or in the done cycle, is ignored. The transfer in progress and its final register values do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, accepted only when idle |
| src_off | input | 16 | Initial source index |
| dst_off | input | 16 | Initial destination index |
| count_in | input | 16 | Number of elements to copy |
| dir | input | 1 | 0 = ascending, 1 = descending |
| word_mode | input | 1 | 1 = 16-bit elements, 0 = 8-bit elements |
| src_seg | input | 16 | Source segment base |
| dst_seg | input | 16 | Destination segment base |
| rd_req | output | 1 | Read request |
| rd_addr | output | 20 | Read physical address |
| rd_valid | input | 1 | Read data valid strobe |
| rd_data | input | 16 | Read data |
| wr_req | output | 1 | Write request |
| wr_addr | output | 20 | Write physical address |
| wr_data | output | 16 | Write data |
| wr_word | output | 1 | Write is 16 bits wide when 1 |
| wr_ready | input | 1 | Write accepted strobe |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| src_idx | output | 16 | Current source index |
| dst_idx | output | 16 | Current destination index |
| count | output | 16 | Remaining element count |

## Verification
The hardest case to reach is a descending word copy whose index crosses zero while its segment base sits near the top of memory. In that case the offset wraps modulo 65536 and the physical sum overflows 20 bits inside one run. A run that starts at offset 0x0002 with segment 0xFFFF covers both. The memory responder in the bench also holds off rd_valid and wr_ready for a random number of cycles. This exercises request hold and index stability. Start pulses with different operands are sent into the middle of a busy transfer and into its done cycle. They must leave the final pointer values unchanged.

// File: rtl/strmove_pkg.sv
package strmove_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_FIN   = 2'd3
  } sm_state_t;

endpackage

// File: rtl/strmove_agu.sv
module strmove_agu #(
  parameter int SEG_W  = 16,
  parameter int OFF_W  = 16,
  parameter int SHIFT  = 4,
  parameter int ADDR_W = 20,
  parameter int CH     = 2
) (
  input  logic [CH-1:0][SEG_W-1:0]  seg,
  input  logic [CH-1:0][OFF_W-1:0]  off,
  output logic [CH-1:0][ADDR_W-1:0] addr
);

  localparam int WIDE_W = SEG_W + SHIFT;

  for (genvar i = 0; i < CH; i++) begin : g_ch
    logic [WIDE_W-1:0] seg_sh;
    logic [WIDE_W-1:0] off_ext;
    logic [WIDE_W-1:0] sum;
    always_comb begin
      seg_sh  = {seg[i], {SHIFT{1'b0}}};
      off_ext = WIDE_W'(off[i]);
      sum     = seg_sh + off_ext;
      addr[i] = sum[ADDR_W-1:0];
    end
  end

endmodule

// File: rtl/strmove_ptrs.sv
module strmove_ptrs #(
  parameter int OFF_W = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             advance,
  input  logic [OFF_W-1:0] src_off,
  input  logic [OFF_W-1:0] dst_off,
  input  logic [CNT_W-1:0] count_in,
  input  logic             dir,
  input  logic             word_mode,
  output logic [OFF_W-1:0] src_idx,
  output logic [OFF_W-1:0] dst_idx,
  output logic [CNT_W-1:0] count,
  output logic             dir_q,
  output logic             word_q,
  output logic             last
);

  localparam logic [OFF_W-1:0] STEP_B = OFF_W'(1);
  localparam logic [OFF_W-1:0] STEP_W = OFF_W'(2);
  localparam logic [CNT_W-1:0] ONE_C  = CNT_W'(1);

  logic [OFF_W-1:0] step;
  logic [OFF_W-1:0] src_nx, dst_nx;
  logic [CNT_W-1:0] cnt_nx;
  logic             dir_nx, word_nx;
  logic             en;

  always_comb begin
    step    = word_q ? STEP_W : STEP_B;
    src_nx  = src_idx;
    dst_nx  = dst_idx;
    cnt_nx  = count;
    dir_nx  = dir_q;
    word_nx = word_q;
    if (load) begin
      src_nx  = src_off;
      dst_nx  = dst_off;
      cnt_nx  = count_in;
      dir_nx  = dir;
      word_nx = word_mode;
    end else if (advance) begin
      src_nx  = dir_q ? (src_idx - step) : (src_idx + step);
      dst_nx  = dir_q ? (dst_idx - step) : (dst_idx + step);
      cnt_nx  = count - ONE_C;
    end
    en   = load | advance;
    last = (count == ONE_C);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_idx <= '0;
      dst_idx <= '0;
      count   <= '0;
      dir_q   <= 1'b0;
      word_q  <= 1'b0;
    end else if (en) begin
      src_idx <= src_nx;
      dst_idx <= dst_nx;
      count   <= cnt_nx;
      dir_q   <= dir_nx;
      word_q  <= word_nx;
    end
  end

  // R6: the two indices move in lockstep, so their distance is kept
  a_r6_lockstep: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !load) |=> ((src_idx - dst_idx) == $past(src_idx - dst_idx)));

  // R6: count is frozen unless loaded or advanced
  a_r6_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !advance) |=> $stable(count));

endmodule

// File: rtl/strmove_ctrl.sv
module strmove_ctrl
  import strmove_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic      zero_cnt,
  input  logic      last,
  input  logic      rd_valid,
  input  logic      wr_ready,
  output sm_state_t state,
  output logic      load,
  output logic      latch_rd,
  output logic      advance
);

  sm_state_t state_nx;

  always_comb begin
    load     = (state == ST_IDLE) && start;
    latch_rd = (state == ST_READ) && rd_valid;
    advance  = (state == ST_WRITE) && wr_ready;
    state_nx = state;
    unique case (state)
      ST_IDLE:  if (start)    state_nx = zero_cnt ? ST_FIN : ST_READ;
      ST_READ:  if (rd_valid) state_nx = ST_WRITE;
      ST_WRITE: if (wr_ready) state_nx = last ? ST_FIN : ST_READ;
      ST_FIN:                 state_nx = ST_IDLE;
      default:                state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  // R4: an unanswered read keeps the sequencer in the read phase
  a_r4_rd_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_READ && !rd_valid) |=> (state == ST_READ));

  // R4: an unanswered write keeps the sequencer in the write phase
  a_r4_wr_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WRITE && !wr_ready) |=> (state == ST_WRITE));

  // R7: the completion state lasts a single cycle
  a_r7_fin_once: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FIN) |=> (state == ST_IDLE));

endmodule

// File: rtl/strmove_seq.sv
module strmove_seq
  import strmove_pkg::*;
#(
  parameter int SEG_W  = 16,
  parameter int OFF_W  = 16,
  parameter int CNT_W  = 16,
  parameter int SHIFT  = 4,
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [OFF_W-1:0]  src_off,
  input  logic [OFF_W-1:0]  dst_off,
  input  logic [CNT_W-1:0]  count_in,
  input  logic              dir,
  input  logic              word_mode,
  input  logic [SEG_W-1:0]  src_seg,
  input  logic [SEG_W-1:0]  dst_seg,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_word,
  input  logic              wr_ready,
  output logic              busy,
  output logic              done,
  output logic [OFF_W-1:0]  src_idx,
  output logic [OFF_W-1:0]  dst_idx,
  output logic [CNT_W-1:0]  count
);

  localparam int BYTE_W = DATA_W / 2;
  localparam int CH     = 2;

  // reset: asserted at once, released through two flops
  logic rst_s1, rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1    <= 1'b0;
      rst_int_n <= 1'b0;
    end else begin
      rst_s1    <= 1'b1;
      rst_int_n <= rst_s1;
    end
  end

  sm_state_t state;
  logic      load, latch_rd, advance, last, dir_q, word_q;

  strmove_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .start    (start),
    .zero_cnt (count_in == '0),
    .last     (last),
    .rd_valid (rd_valid),
    .wr_ready (wr_ready),
    .state    (state),
    .load     (load),
    .latch_rd (latch_rd),
    .advance  (advance)
  );

  strmove_ptrs #(.OFF_W(OFF_W), .CNT_W(CNT_W)) u_ptrs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .load      (load),
    .advance   (advance),
    .src_off   (src_off),
    .dst_off   (dst_off),
    .count_in  (count_in),
    .dir       (dir),
    .word_mode (word_mode),
    .src_idx   (src_idx),
    .dst_idx   (dst_idx),
    .count     (count),
    .dir_q     (dir_q),
    .word_q    (word_q),
    .last      (last)
  );

  // segment bases and read data, each with its own enable
  logic [SEG_W-1:0]  src_seg_q, dst_seg_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      src_seg_q <= '0;
      dst_seg_q <= '0;
    end else if (load) begin
      src_seg_q <= src_seg;
      dst_seg_q <= dst_seg;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)    data_q <= '0;
    else if (latch_rd) data_q <= rd_data;
  end

  logic [CH-1:0][SEG_W-1:0]  agu_seg;
  logic [CH-1:0][OFF_W-1:0]  agu_off;
  logic [CH-1:0][ADDR_W-1:0] agu_addr;

  always_comb begin
    agu_seg[0] = src_seg_q;
    agu_seg[1] = dst_seg_q;
    agu_off[0] = src_idx;
    agu_off[1] = dst_idx;
  end

  strmove_agu #(
    .SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT), .ADDR_W(ADDR_W), .CH(CH)
  ) u_agu (
    .seg  (agu_seg),
    .off  (agu_off),
    .addr (agu_addr)
  );

  always_comb begin
    rd_req  = (state == ST_READ);
    wr_req  = (state == ST_WRITE);
    busy    = rd_req | wr_req;
    done    = (state == ST_FIN);
    rd_addr = agu_addr[0];
    wr_addr = agu_addr[1];
    wr_word = word_q;
    wr_data = word_q ? data_q : {{(DATA_W-BYTE_W){1'b0}}, data_q[BYTE_W-1:0]};
  end

  // R4: read and write requests are exclusive
  a_r4_excl: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(rd_req && wr_req));

  // R4: a pending read keeps its address
  a_r4_rd_addr_hold: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));

  // R7: done never overlaps busy
  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_int_n)
    done |-> !busy);

  // R8: idle without a start leaves the pointers alone
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!busy && !start) |=> ($stable(src_idx) && $stable(dst_idx) && $stable(count)));

  // R9: start during a transfer does not restart it
  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_req && !wr_ready && start) |=> wr_req);

endmodule

// File: tb/tb_strmove_seq.sv
module tb_strmove_seq;

  logic        clk, rst_n, start, dir, word_mode, rd_valid, wr_ready;
  logic [15:0] src_off, dst_off, count_in, src_seg, dst_seg, rd_data;
  logic        rd_req, wr_req, wr_word, busy, done;
  logic [19:0] rd_addr, wr_addr;
  logic [15:0] wr_data, src_idx, dst_idx, count;

  strmove_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .src_off(src_off), .dst_off(dst_off),
    .count_in(count_in), .dir(dir), .word_mode(word_mode), .src_seg(src_seg),
    .dst_seg(dst_seg), .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid),
    .rd_data(rd_data), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_word(wr_word), .wr_ready(wr_ready), .busy(busy), .done(done),
    .src_idx(src_idx), .dst_idx(dst_idx), .count(count)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_run, n_fail, cyc;
  int slow;

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // behavioural reference: phase 0 idle, 1 read, 2 write, 3 finished
  int m_ph, m_src, m_dst, m_cnt, m_data, m_word, m_dir, m_sseg, m_dseg;

  function automatic int phys(int seg, int off);
    return ((seg * 16) + off) % 1048576;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_src = 0; m_dst = 0; m_cnt = 0; m_data = 0;
      m_word = 0; m_dir = 0; m_sseg = 0; m_dseg = 0;
    end else begin
      case (m_ph)
        0: if (start) begin
             m_src = src_off; m_dst = dst_off; m_cnt = count_in;
             m_dir = dir; m_word = word_mode; m_sseg = src_seg; m_dseg = dst_seg;
             m_ph = (count_in == 0) ? 3 : 1;
           end
        1: if (rd_valid) begin m_data = rd_data; m_ph = 2; end
        2: if (wr_ready) begin
             int st;
             st = m_word ? 2 : 1;
             if (m_dir) begin
               m_src = (m_src - st + 65536) % 65536;
               m_dst = (m_dst - st + 65536) % 65536;
             end else begin
               m_src = (m_src + st) % 65536;
               m_dst = (m_dst + st) % 65536;
             end
             m_cnt = m_cnt - 1;
             m_ph = (m_cnt == 0) ? 3 : 1;
           end
        default: m_ph = 0;
      endcase
    end
  end

  // compare every cycle, away from the rising edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk("R7 busy", busy, (m_ph == 1 || m_ph == 2) ? 1 : 0);
      chk("R7 done", done, (m_ph == 3) ? 1 : 0);
      chk("R4 rd_req", rd_req, (m_ph == 1) ? 1 : 0);
      chk("R4 wr_req", wr_req, (m_ph == 2) ? 1 : 0);
      chk("R6 src_idx", src_idx, m_src);
      chk("R6 dst_idx", dst_idx, m_dst);
      chk("R6 count", count, m_cnt);
      if (m_ph == 1) chk("R3 rd_addr", rd_addr, phys(m_sseg, m_src));
      if (m_ph == 2) begin
        chk("R3 wr_addr", wr_addr, phys(m_dseg, m_dst));
        chk("R5 wr_data", wr_data, m_word ? m_data : (m_data % 256));
        chk("R5 wr_word", wr_word, m_word);
      end
    end
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  // memory responder with random latency
  int rdly, wdly;
  always @(negedge clk) begin
    if (!rd_req) begin
      rd_valid = 1'b0;
      rdly = slow ? ($urandom % 4) : 0;
    end else if (rdly == 0) begin
      rd_valid = 1'b1;
      rd_data  = 16'($urandom);
    end else begin
      rdly--;
    end
    if (!wr_req) begin
      wr_ready = 1'b0;
      wdly = slow ? ($urandom % 4) : 0;
    end else if (wdly == 0) begin
      wr_ready = 1'b1;
    end else begin
      wdly--;
    end
  end

  task automatic run(int so, int d_o, int cn, int dr, int wm, int ss, int ds, int inject);
    int st, ex_s;
    @(negedge clk);
    src_off = 16'(so); dst_off = 16'(d_o); count_in = 16'(cn);
    dir = dr[0]; word_mode = wm[0]; src_seg = 16'(ss); dst_seg = 16'(ds);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (inject) begin
      repeat (3) @(negedge clk);
      src_off = 16'h1234; dst_off = 16'h4321; count_in = 16'd7; dir = ~dir;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int i = 0; i < 2000 && !done; i++) @(negedge clk);
    if (inject) begin
      start = 1'b1;                    // start in the done cycle
      @(negedge clk);
      start = 1'b0;
    end
    st = wm ? 2 : 1;
    ex_s = dr ? ((so - cn * st) % 65536 + 65536) % 65536 : (so + cn * st) % 65536;
    repeat (3) @(negedge clk);
    chk(inject ? "R9 final src_idx" : "R8 held src_idx", src_idx, ex_s);
    chk(inject ? "R9 final count" : "R8 held count", count, 0);
    chk("R8 idle busy", busy, 0);
  endtask

  initial begin
    n_run = 0; n_fail = 0; cyc = 0; slow = 0;
    rst_n = 1'b0; start = 1'b0; dir = 1'b0; word_mode = 1'b0;
    src_off = '0; dst_off = '0; count_in = '0; src_seg = '0; dst_seg = '0;
    rd_valid = 1'b0; wr_ready = 1'b0; rd_data = '0;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", busy, 0);
    chk("R1 req in reset", rd_req | wr_req | done, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 src_idx after reset", src_idx, 0);
    chk("R1 count after reset", count, 0);

    // R2: zero count gives done next cycle, no access
    @(negedge clk);
    count_in = 16'd0; src_off = 16'h0040; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 done after zero count", done, 1);
    chk("R2 no read on zero count", rd_req, 0);
    @(negedge clk);
    chk("R2 src_idx loaded", src_idx, 16'h0040);

    run(16'h0100, 16'h0200, 5, 0, 0, 16'h1000, 16'h2000, 0);   // byte up
    run(16'h0300, 16'h0500, 4, 0, 1, 16'h1000, 16'h3000, 0);   // word up
    slow = 1;
    run(16'h0010, 16'h0020, 3, 1, 0, 16'h0800, 16'h0900, 0);   // byte down
    run(16'h0002, 16'hFFFE, 3, 1, 1, 16'hFFFF, 16'hFFF0, 0);   // word down, wraps
    run(16'hFFFF, 16'h0000, 2, 0, 0, 16'hF000, 16'h0001, 0);   // byte up, wraps
    run(16'h0000, 16'h0100, 1, 0, 1, 16'h0000, 16'h0000, 0);   // single word
    run(16'h0400, 16'h0600, 6, 0, 1, 16'h2000, 16'h4000, 1);   // restart attempts
    run(16'h0050, 16'h0070, 5, 1, 0, 16'h0123, 16'h0456, 1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule